// File: doc/BRIEF.md
# External Interrupt Line Register Bank

This block holds the per-line configuration and status of a parameterised set of external interrupt lines and exposes it on a simple 32-bit word-addressed bus with byte enables. Software enables lines, pends or unpends them, reads back which lines the core reports as active, and programs an 8-bit priority for each line. External line n corresponds to exception number n+16; the bus views below are indexed by the external line number n. The bank also captures rising edges on the interrupt input lines as pending requests. It holds three system pending flags (non-maskable, deferred service call, periodic tick), a 3-bit priority grouping field and a software trigger port.

The enable, pending and priority state leaves the block on flat output vectors that feed a separate priority resolver. The resolver returns its chosen vector number, and the bank shows that number in the control/state word. Choosing the winning vector and escalating faults happen elsewhere.

Top module: `irq_line_bank`

## Requirements
- R1: After a synchronous reset, all enable, pending and priority state, the three system pending flags, the grouping field and `bus_rdata` are zero.
- R2: Writing a word at 0x100+4w sets the enable of line 32w+i for each bit i that is 1 and lies in an enabled byte lane; the same write at 0x180+4w clears those enables; 0 bits change nothing; reads at either address return the enable bits of lines 32w..32w+31.
- R3: The pending windows at 0x200+4w (set) and 0x280+4w (clear) behave exactly as R2 for the pending bits.
- R4: A low-to-high change of `irq_in[n]` sets the pending bit of line n, visible after the clock edge that samples the high level; a falling edge does not clear it; a line already high when reset is released does not pend; an edge in the same cycle as a clear write to that bit leaves it pending.
- R5: Reads at 0x300+4w return `irq_active` for lines 32w..32w+31, and writes there change no state.
- R6: In the priority window 0x400..0x5EF, byte lane k of word w (bits 8k+7:8k) is the priority of line 4w+k; each lane is written only when its byte enable is set, and reads return all four.
- R7: Lines at or above NUM_LINES read as zero and ignore writes in every window, and unmapped addresses read as zero.
- R8: A full-word write at 0xF00 pends line wdata[8:0] when that value is below NUM_LINES and either `bus_priv` or `user_pend_ok` is 1; otherwise, or with any byte enable clear, nothing changes.
- R9: A full-word write at 0xD04 sets the non-maskable flag when bit 31 is 1; bit 28 sets the service-call flag, else bit 27 clears it; bit 26 sets the tick flag, else bit 25 clears it.
- R10: A read at 0xD04 returns the non-maskable flag at bit 31, the service-call flag at bit 28, the tick flag at bit 26, bit 22 as 1 when any line is pending, and `top_vec` in bits 19:12, with the other bits zero.
- R11: A read at 0x004 returns NUM_LINES/32 - 1.
- R12: A full-word write at 0xD0C whose bits 31:16 equal 0x05FA loads the grouping field from bits 10:8; any other write there is ignored; reads return 0xFA05 in bits 31:16 and the grouping field in bits 10:8.
- R13: Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access comes from privileged code |
| bus_rdata | output | 32 | Registered read data |
| user_pend_ok | input | 1 | Lets unprivileged code use the software trigger |
| irq_in | input | NUM_LINES | External interrupt lines |
| irq_active | input | NUM_LINES | Per-line active status from the core |
| top_vec | input | 8 | Vector number chosen by the resolver |
| ext_enable | output | NUM_LINES | Per-line enable |
| ext_pend | output | NUM_LINES | Per-line pending |
| ext_prio | output | 8*NUM_LINES | Per-line priority, line n at bits 8n+7:8n |
| nmi_pend | output | 1 | Non-maskable pending flag |
| pendsv_pend | output | 1 | Deferred service call pending flag |
| systick_pend | output | 1 | Periodic tick pending flag |
| prio_group | output | 3 | Priority grouping field |

## Verification
The hardest case to reach is a rising edge on a line that lands in the same clock as a software clear of that line's pending bit. The bench first pends the line through the set window, then raises the line and issues the clear write on the same falling edge, so both reach one rising edge together. A second hard case is a line held high through reset: the bench drives it high before releasing reset and checks that no request appears. The software trigger sweep covers every line, the privilege gate in both states, a value past the last line and a value with bit 9 set that must be masked away.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

  localparam logic [11:0] OFS_TYPE   = 12'h004;
  localparam logic [11:0] WIN_SETEN  = 12'h100;
  localparam logic [11:0] WIN_CLREN  = 12'h180;
  localparam logic [11:0] WIN_SETPD  = 12'h200;
  localparam logic [11:0] WIN_CLRPD  = 12'h280;
  localparam logic [11:0] WIN_ACT    = 12'h300;
  localparam logic [11:0] WIN_SPAN   = 12'h040;
  localparam logic [11:0] WIN_PRIO   = 12'h400;
  localparam logic [11:0] PRIO_LAST  = 12'h5EF;
  localparam logic [11:0] OFS_CTRL   = 12'hD04;
  localparam logic [11:0] OFS_GRP    = 12'hD0C;
  localparam logic [11:0] OFS_SWTRIG = 12'hF00;

  localparam logic [15:0] GRP_KEY_WR = 16'h05FA;
  localparam logic [15:0] GRP_KEY_RD = 16'hFA05;

  localparam int PRIO_W   = 8;
  localparam int WORD_IDX = 7;

  typedef enum logic [3:0] {
    K_NONE, K_EN, K_PD, K_ACT, K_PRIO, K_TYPE, K_CTRL, K_GRP, K_SWTRIG
  } kind_e;

  typedef struct packed {
    kind_e                 kind;
    logic                  set_side;
    logic [WORD_IDX-1:0]   word;
  } dec_t;

endpackage

// File: rtl/irqb_decode.sv
module irqb_decode
  import irqb_pkg::*;
(
  input  logic [11:0] addr,
  output dec_t        dec
);

  logic [11:0] prio_off;
  assign prio_off = addr - WIN_PRIO;

  always_comb begin
    dec.kind     = K_NONE;
    dec.set_side = 1'b0;
    dec.word     = '0;
    if (addr >= WIN_SETEN && addr < WIN_SETEN + WIN_SPAN) begin
      dec.kind     = K_EN;
      dec.set_side = 1'b1;
      dec.word     = WORD_IDX'(addr[5:2]);
    end else if (addr >= WIN_CLREN && addr < WIN_CLREN + WIN_SPAN) begin
      dec.kind     = K_EN;
      dec.word     = WORD_IDX'(addr[5:2]);
    end else if (addr >= WIN_SETPD && addr < WIN_SETPD + WIN_SPAN) begin
      dec.kind     = K_PD;
      dec.set_side = 1'b1;
      dec.word     = WORD_IDX'(addr[5:2]);
    end else if (addr >= WIN_CLRPD && addr < WIN_CLRPD + WIN_SPAN) begin
      dec.kind     = K_PD;
      dec.word     = WORD_IDX'(addr[5:2]);
    end else if (addr >= WIN_ACT && addr < WIN_ACT + WIN_SPAN) begin
      dec.kind     = K_ACT;
      dec.word     = WORD_IDX'(addr[5:2]);
    end else if (addr >= WIN_PRIO && addr <= PRIO_LAST) begin
      dec.kind     = K_PRIO;
      dec.word     = WORD_IDX'(prio_off[11:2]);
    end else if (addr[11:2] == OFS_TYPE[11:2]) begin
      dec.kind     = K_TYPE;
    end else if (addr[11:2] == OFS_CTRL[11:2]) begin
      dec.kind     = K_CTRL;
    end else if (addr[11:2] == OFS_GRP[11:2]) begin
      dec.kind     = K_GRP;
    end else if (addr[11:2] == OFS_SWTRIG[11:2]) begin
      dec.kind     = K_SWTRIG;
    end
  end

endmodule

// File: rtl/irqb_edge.sv
module irqb_edge #(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line,
  output logic [NUM_LINES-1:0] rise
);

  logic [NUM_LINES-1:0] line_q;

  // During reset the history follows the lines, so a level already
  // high when reset drops is not seen as an edge.
  always_ff @(posedge clk) begin
    if (rst) line_q <= line;
    else     line_q <= line;
  end

  assign rise = line & ~line_q;

endmodule

// File: rtl/irqb_bitvec.sv
module irqb_bitvec
  import irqb_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 set_side,
  input  logic [WORD_IDX-1:0]  word,
  input  logic [3:0]           be,
  input  logic [31:0]          wdata,
  input  logic [NUM_LINES-1:0] set_ext,
  output logic [NUM_LINES-1:0] state,
  output logic [31:0]          rd_word
);

  logic [NUM_LINES-1:0] wmask;

  always_comb begin
    wmask   = '0;
    rd_word = '0;
    for (int v = 0; v < NUM_LINES; v++) begin
      if ((v / 32) == int'(word)) begin
        if (be[(v % 32) / 8]) wmask[v] = wdata[v % 32];
        rd_word[v % 32] = state[v];
      end
    end
  end

  // External set requests win over a clear in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= '0;
    end else if (wr_en) begin
      if (set_side) state <= state | wmask | set_ext;
      else          state <= (state & ~wmask) | set_ext;
    end else begin
      state <= state | set_ext;
    end
  end

  p_clear_never_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !set_side && set_ext == '0) |=> ((state & ~$past(state)) == '0));

endmodule

// File: rtl/irqb_prio.sv
module irqb_prio
  import irqb_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [WORD_IDX-1:0]           word,
  input  logic [3:0]                    be,
  input  logic [31:0]                   wdata,
  output logic [PRIO_W*NUM_LINES-1:0]   prio_flat,
  output logic [31:0]                   rd_word
);

  // Every priority drives the resolver in parallel, so the store is a
  // flop array rather than a single-port memory.
  logic [PRIO_W-1:0] mem [NUM_LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int v = 0; v < NUM_LINES; v++) mem[v] <= '0;
    end else if (wr_en) begin
      for (int v = 0; v < NUM_LINES; v++) begin
        if ((v / 4) == int'(word) && be[v % 4])
          mem[v] <= wdata[PRIO_W*(v % 4) +: PRIO_W];
      end
    end
  end

  always_comb begin
    rd_word = '0;
    for (int v = 0; v < NUM_LINES; v++) begin
      if ((v / 4) == int'(word)) rd_word[PRIO_W*(v % 4) +: PRIO_W] = mem[v];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_flat
      assign prio_flat[PRIO_W*g +: PRIO_W] = mem[g];
    end
  endgenerate

endmodule

// File: rtl/irq_line_bank.sv
module irq_line_bank
  import irqb_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [11:0]                   bus_addr,
  input  logic [3:0]                    bus_be,
  input  logic [31:0]                   bus_wdata,
  input  logic                          bus_priv,
  output logic [31:0]                   bus_rdata,
  input  logic                          user_pend_ok,
  input  logic [NUM_LINES-1:0]          irq_in,
  input  logic [NUM_LINES-1:0]          irq_active,
  input  logic [7:0]                    top_vec,
  output logic [NUM_LINES-1:0]          ext_enable,
  output logic [NUM_LINES-1:0]          ext_pend,
  output logic [PRIO_W*NUM_LINES-1:0]   ext_prio,
  output logic                          nmi_pend,
  output logic                          pendsv_pend,
  output logic                          systick_pend,
  output logic [2:0]                    prio_group
);

  localparam logic [31:0] TYPE_VAL = 32'(NUM_LINES / 32 - 1);
  localparam int          TRIG_W   = 9;

  dec_t dec;
  logic wr_req, rd_req, full_word;
  logic [NUM_LINES-1:0] rise, sw_set;
  logic [31:0] en_rd, pd_rd, pr_rd, act_rd, rd_next;
  logic trig_ok;

  assign wr_req    = bus_sel & bus_wr;
  assign rd_req    = bus_sel & ~bus_wr;
  assign full_word = (bus_be == 4'hF);

  irqb_decode u_dec (.addr(bus_addr), .dec(dec));

  irqb_edge #(.NUM_LINES(NUM_LINES)) u_edge (
    .clk(clk), .rst(rst), .line(irq_in), .rise(rise)
  );

  assign trig_ok = wr_req && dec.kind == K_SWTRIG && full_word &&
                   (bus_priv || user_pend_ok);

  always_comb begin
    sw_set = '0;
    for (int v = 0; v < NUM_LINES; v++) begin
      if (trig_ok && bus_wdata[TRIG_W-1:0] == TRIG_W'(v)) sw_set[v] = 1'b1;
    end
  end

  irqb_bitvec #(.NUM_LINES(NUM_LINES)) u_en (
    .clk(clk), .rst(rst),
    .wr_en(wr_req && dec.kind == K_EN), .set_side(dec.set_side),
    .word(dec.word), .be(bus_be), .wdata(bus_wdata),
    .set_ext('0), .state(ext_enable), .rd_word(en_rd)
  );

  irqb_bitvec #(.NUM_LINES(NUM_LINES)) u_pd (
    .clk(clk), .rst(rst),
    .wr_en(wr_req && dec.kind == K_PD), .set_side(dec.set_side),
    .word(dec.word), .be(bus_be), .wdata(bus_wdata),
    .set_ext(rise | sw_set), .state(ext_pend), .rd_word(pd_rd)
  );

  irqb_prio #(.NUM_LINES(NUM_LINES)) u_prio (
    .clk(clk), .rst(rst),
    .wr_en(wr_req && dec.kind == K_PRIO),
    .word(dec.word), .be(bus_be), .wdata(bus_wdata),
    .prio_flat(ext_prio), .rd_word(pr_rd)
  );

  always_comb begin
    act_rd = '0;
    for (int v = 0; v < NUM_LINES; v++) begin
      if ((v / 32) == int'(dec.word)) act_rd[v % 32] = irq_active[v];
    end
  end

  // System pending flags: set takes precedence over clear in each pair.
  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_pend     <= 1'b0;
      pendsv_pend  <= 1'b0;
      systick_pend <= 1'b0;
    end else if (wr_req && dec.kind == K_CTRL && full_word) begin
      if (bus_wdata[31]) nmi_pend <= 1'b1;
      if (bus_wdata[28])      pendsv_pend <= 1'b1;
      else if (bus_wdata[27]) pendsv_pend <= 1'b0;
      if (bus_wdata[26])      systick_pend <= 1'b1;
      else if (bus_wdata[25]) systick_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prio_group <= '0;
    end else if (wr_req && dec.kind == K_GRP && full_word &&
                 bus_wdata[31:16] == GRP_KEY_WR) begin
      prio_group <= bus_wdata[10:8];
    end
  end

  always_comb begin
    unique case (dec.kind)
      K_EN:    rd_next = en_rd;
      K_PD:    rd_next = pd_rd;
      K_ACT:   rd_next = act_rd;
      K_PRIO:  rd_next = pr_rd;
      K_TYPE:  rd_next = TYPE_VAL;
      K_CTRL:  rd_next = {nmi_pend, 2'b00, pendsv_pend, 1'b0, systick_pend,
                          3'b000, |ext_pend, 2'b00, top_vec, 12'h000};
      K_GRP:   rd_next = {GRP_KEY_RD, 5'b00000, prio_group, 8'h00};
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_next;
  end

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_edge_chk
      p_edge_pends_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_in[g]) |=> ext_pend[g]);
    end
  endgenerate

  p_pend_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (ext_pend[0] && !wr_req) |=> ext_pend[0]);

  p_active_ro_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_req && bus_addr[11:6] == 6'h0C) |=> ($stable(ext_enable) && $stable(ext_prio)));

  p_group_key_r12: assert property (@(posedge clk) disable iff (rst)
    !$stable(prio_group) |-> $past(wr_req && bus_wdata[31:16] == GRP_KEY_WR));

  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(bus_rdata));

endmodule

// File: tb/tb_irq_line_bank.sv
module tb_irq_line_bank;

  localparam int NL = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b1;
  logic [11:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic user_pend_ok = 1'b0;
  logic [NL-1:0] irq_in = '0;
  logic [NL-1:0] irq_active = '0;
  logic [7:0] top_vec = '0;
  logic [NL-1:0] ext_enable, ext_pend;
  logic [8*NL-1:0] ext_prio;
  logic nmi_pend, pendsv_pend, systick_pend;
  logic [2:0] prio_group;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irq_line_bank #(.NUM_LINES(NL)) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_priv(bus_priv), .bus_rdata(bus_rdata), .user_pend_ok(user_pend_ok),
    .irq_in(irq_in), .irq_active(irq_active), .top_vec(top_vec),
    .ext_enable(ext_enable), .ext_pend(ext_pend), .ext_prio(ext_prio),
    .nmi_pend(nmi_pend), .pendsv_pend(pendsv_pend),
    .systick_pend(systick_pend), .prio_group(prio_group)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    input logic [3:0] be, input logic pv);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    bus_be = be; bus_priv = pv;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  function automatic logic [7:0] pval(int v);
    return 8'((v * 37 + 11) % 256);
  endfunction

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [63:0] exp_v;

    // line 5 held high across reset release (R4)
    irq_in[5] = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 enable", ext_enable, 0);
    chk("R4 high-at-reset no pend", ext_pend, 0);
    chk("R1 prio", {63'd0, |ext_prio}, 0);
    chk("R1 flags", {nmi_pend, pendsv_pend, systick_pend, prio_group}, 0);
    chk("R1 rdata", bus_rdata, 0);
    irq_in[5] = 1'b0;

    rd(12'h004, r); chk("R11 type", r, NL / 32 - 1);

    // R2 enable sweep
    exp_v = '0;
    for (int n = 0; n < NL; n++) begin
      wr(12'h100 + 12'(4 * (n / 32)), 32'h1 << (n % 32), 4'hF, 1'b1);
      exp_v[n] = 1'b1;
      chk("R2 set enable", ext_enable, exp_v);
    end
    wr(12'h180, 32'hA5A5A5A5, 4'b0101, 1'b1);
    exp_v[31:0] = ~32'h00A500A5;
    chk("R2 lane clear", ext_enable, exp_v);
    wr(12'h100, 32'h0, 4'hF, 1'b1);
    chk("R2 zero no effect", ext_enable, exp_v);
    for (int w = 0; w < 2; w++) begin
      rd(12'h100 + 12'(4 * w), r); chk("R2 read set window", r, exp_v[32*w +: 32]);
      rd(12'h180 + 12'(4 * w), r); chk("R2 read clear window", r, exp_v[32*w +: 32]);
    end
    wr(12'h108, 32'hFFFFFFFF, 4'hF, 1'b1);
    chk("R7 enable beyond range", ext_enable, exp_v);
    rd(12'h108, r); chk("R7 read beyond range", r, 0);
    rd(12'h800, r); chk("R7 unmapped", r, 0);
    wr(12'h180, 32'hFFFFFFFF, 4'hF, 1'b1);
    wr(12'h184, 32'hFFFFFFFF, 4'hF, 1'b1);
    chk("R2 clear all", ext_enable, 0);

    // R3 pending windows
    exp_v = '0;
    for (int n = 0; n < NL; n += 3) begin
      wr(12'h200 + 12'(4 * (n / 32)), 32'h1 << (n % 32), 4'hF, 1'b1);
      exp_v[n] = 1'b1;
    end
    chk("R3 set pending", ext_pend, exp_v);
    rd(12'h204, r); chk("R3 read set window", r, exp_v[63:32]);
    rd(12'h284, r); chk("R3 read clear window", r, exp_v[63:32]);
    wr(12'h280, 32'hFFFFFFFF, 4'b1110, 1'b1);
    exp_v[31:8] = '0;
    chk("R3 lane clear", ext_pend, exp_v);
    wr(12'h280, 32'hFFFFFFFF, 4'hF, 1'b1);
    wr(12'h284, 32'hFFFFFFFF, 4'hF, 1'b1);
    chk("R3 clear all", ext_pend, 0);

    // R4 edge capture on every line
    for (int n = 0; n < NL; n++) begin
      @(negedge clk); irq_in[n] = 1'b1;
      @(negedge clk);
      chk("R4 rising edge pends", ext_pend, 64'h1 << n);
      irq_in[n] = 1'b0;
      @(negedge clk);
      chk("R4 falling edge keeps", ext_pend, 64'h1 << n);
      wr(12'h280 + 12'(4 * (n / 32)), 32'h1 << (n % 32), 4'hF, 1'b1);
      chk("R4 cleared", ext_pend, 0);
    end
    // edge and clear in the same cycle
    wr(12'h200, 32'h8, 4'hF, 1'b1);
    @(negedge clk);
    irq_in[3] = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h280; bus_wdata = 32'h8; bus_be = 4'hF;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    chk("R4 edge beats clear", ext_pend, 64'h8);
    wr(12'h280, 32'h8, 4'hF, 1'b1);
    chk("R4 held level no repend", ext_pend, 0);
    irq_in[3] = 1'b0;

    // R5 active window
    irq_active = 64'hDEADBEEF_01234567;
    rd(12'h300, r); chk("R5 active low", r, 32'h01234567);
    rd(12'h304, r); chk("R5 active high", r, 32'hDEADBEEF);
    wr(12'h300, 32'hFFFFFFFF, 4'hF, 1'b1);
    chk("R5 write ignored", {ext_enable | ext_pend}, 0);
    rd(12'h300, r); chk("R5 readback unchanged", r, 32'h01234567);

    // R6 priorities
    for (int w = 0; w < NL / 4; w++)
      wr(12'h400 + 12'(4 * w),
         {pval(4*w+3), pval(4*w+2), pval(4*w+1), pval(4*w)}, 4'hF, 1'b1);
    for (int v = 0; v < NL; v++) chk("R6 prio out", ext_prio[8*v +: 8], pval(v));
    wr(12'h400, 32'hEEEEEEEE, 4'b0010, 1'b1);
    rd(12'h400, r); chk("R6 byte lane", r, {pval(3), pval(2), 8'hEE, pval(0)});
    rd(12'h43C, r); chk("R6 last word", r, {pval(63), pval(62), pval(61), pval(60)});
    wr(12'h440, 32'hFFFFFFFF, 4'hF, 1'b1);
    rd(12'h440, r); chk("R7 prio beyond range", r, 0);
    chk("R7 prio unchanged", ext_prio[8*60 +: 32],
        {pval(63), pval(62), pval(61), pval(60)});

    // R8 software trigger
    exp_v = '0;
    for (int n = 0; n < NL; n++) begin
      wr(12'hF00, 32'(n), 4'hF, 1'b1);
      exp_v[n] = 1'b1;
    end
    chk("R8 priv trigger all", ext_pend, exp_v);
    wr(12'h280, 32'hFFFFFFFF, 4'hF, 1'b1);
    wr(12'h284, 32'hFFFFFFFF, 4'hF, 1'b1);
    user_pend_ok = 1'b0;
    wr(12'hF00, 32'd7, 4'hF, 1'b0);
    chk("R8 user blocked", ext_pend, 0);
    user_pend_ok = 1'b1;
    wr(12'hF00, 32'd9, 4'hF, 1'b0);
    chk("R8 user allowed", ext_pend, 64'h200);
    wr(12'hF00, 32'(NL), 4'hF, 1'b1);
    chk("R8 out of range", ext_pend, 64'h200);
    wr(12'hF00, 32'h202, 4'hF, 1'b1);
    chk("R8 nine-bit field", ext_pend, 64'h204);
    wr(12'hF00, 32'd4, 4'h1, 1'b1);
    chk("R8 partial ignored", ext_pend, 64'h204);
    wr(12'h280, 32'hFFFFFFFF, 4'hF, 1'b1);

    // R9 / R10 control word
    top_vec = 8'h5A;
    wr(12'hD04, (32'h1 << 28) | (32'h1 << 26), 4'hF, 1'b1);
    chk("R9 set pendsv/tick", {nmi_pend, pendsv_pend, systick_pend}, 3'b011);
    rd(12'hD04, r);
    chk("R10 read flags", r, (32'h1 << 28) | (32'h1 << 26) | (32'h5A << 12));
    wr(12'hD04, (32'h1 << 28) | (32'h1 << 27), 4'hF, 1'b1);
    chk("R9 set over clear", pendsv_pend, 1);
    wr(12'hD04, (32'h1 << 27) | (32'h1 << 25), 4'hF, 1'b1);
    chk("R9 clear both", {pendsv_pend, systick_pend}, 0);
    wr(12'hD04, 32'h1 << 28, 4'h8, 1'b1);
    chk("R9 partial ignored", pendsv_pend, 0);
    wr(12'hD04, 32'h1 << 31, 4'hF, 1'b1);
    chk("R9 nmi", nmi_pend, 1);
    wr(12'h204, 32'h1, 4'hF, 1'b1);
    rd(12'hD04, r);
    chk("R10 any pending", r, (32'h1 << 31) | (32'h1 << 22) | (32'h5A << 12));

    // R12 grouping field
    wr(12'hD0C, 32'h12340300, 4'hF, 1'b1);
    chk("R12 bad key", prio_group, 0);
    for (int g = 0; g < 8; g++) begin
      wr(12'hD0C, {16'h05FA, 5'd0, 3'(g), 8'h00}, 4'hF, 1'b1);
      chk("R12 group", prio_group, g);
      rd(12'hD0C, r);
      chk("R12 readback", r, {16'hFA05, 5'd0, 3'(g), 8'h00});
    end

    // R13 read data hold
    rd(12'h004, r);
    repeat (3) @(negedge clk);
    chk("R13 hold", bus_rdata, NL / 32 - 1);
    rd(12'h800, r); chk("R13 next read", r, 0);

    finish_run();
  end

endmodule